// File: doc/BRIEF.md
# Peripheral Register Front End with Set/Clear Shadow Registers and Interrupt Mask

This block is the software-facing register file of a peripheral. It decodes a word-wide register bus (word address, write strobe, read strobe, write data, registered read data). It holds four kinds of state. A command register is write-only and turns every one bit in the written word into a single-cycle pulse toward the peripheral logic. A mode register is read/write and holds the configuration. A status vector is changed only through a pair of set and clear addresses and read through a third address. An interrupt mask is handled the same way as the status vector.

Peripheral logic raises status bits through a per-bit set-pulse input. The block folds the status bits that the mask allows into one interrupt request. Because setting and clearing use separate addresses, one write changes exactly the bits written as one, and software needs no read-modify-write sequence.

Word address map (ADDR_W bits): 0 command, 1 mode, 2 status set, 3 status clear, 4 status view, 5 mask set, 6 mask clear, 7 mask view. Every other address is unmapped.

Top module: `periph_regfront`

## Requirements
- R1: A write to address 2 sets every status bit whose write-data bit is one. Bits written as zero keep their value.
- R2: A write to address 3 clears every status bit whose write-data bit is one. Bits written as zero keep their value.
- R3: A one on `evt_set[i]` sets status bit i at the next clock edge. If a status-clear write has a one in bit i in the same cycle, the bit ends cleared.
- R4: A write to address 0 drives `cmd_pulse` for exactly the cycle after the write, equal to the low CMD_W bits of the written data. `cmd_pulse` is zero in every other cycle, and zero bits of the write produce no pulse.
- R5: The mode register at address 1 is zero after reset. It stores the low MODE_W bits of a write and returns them on a read, with all higher bits zero.
- R6: The interrupt mask changes only through address 5, which sets the bits written as one, and address 6, which clears the bits written as one. The mask reads back at address 7.
- R7: `irq` is the OR over all bits of status AND mask. It reflects a register write or event in the cycle after that edge.
- R8: Reads of the write-only addresses (0, 2, 3, 5, 6) and of unmapped addresses return zero. Status and mask reads carry zeros above bit STAT_W-1.
- R9: Reset clears status, mask, mode, `cmd_pulse`, `rdata` and `irq`.
- R10: `rdata` is registered. It presents the value addressed by a read in the cycle after `rd_en` is high, and it is zero in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| evt_set | input | STAT_W | Per-bit status set pulses from peripheral logic |
| cmd_pulse | output | CMD_W | Single-cycle command pulses to peripheral logic |
| mode | output | MODE_W | Current mode register value |
| irq | output | 1 | Interrupt request: OR of masked status |

## Verification
The hardest case to reach is a collision on one bit in one cycle: a peripheral event that sets the bit and a software clear write that names the same bit. From the ports this needs `evt_set` and the status-clear write driven on the same edge. The bench drives both in a directed case and then reads status and `irq` to check that the clear wins. The random phase keeps producing such overlaps, because it sends event pulses alongside every kind of write and compares status against a model in which the clear has priority.

// File: rtl/regfront_pkg.sv
package regfront_pkg;
  localparam int unsigned OFS_CMD   = 0;
  localparam int unsigned OFS_MODE  = 1;
  localparam int unsigned OFS_SSET  = 2;
  localparam int unsigned OFS_SCLR  = 3;
  localparam int unsigned OFS_SVIEW = 4;
  localparam int unsigned OFS_MSET  = 5;
  localparam int unsigned OFS_MCLR  = 6;
  localparam int unsigned OFS_MVIEW = 7;

  typedef struct packed {
    logic cmd;
    logic mode;
    logic sset;
    logic sclr;
    logic mset;
    logic mclr;
  } wr_sel_t;
endpackage

// File: rtl/regfront_decode.sv
module regfront_decode
  import regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output wr_sel_t           wsel
);
  always_comb begin
    wsel = '0;
    if (wr_en) begin
      case (int'(addr))
        OFS_CMD:  wsel.cmd  = 1'b1;
        OFS_MODE: wsel.mode = 1'b1;
        OFS_SSET: wsel.sset = 1'b1;
        OFS_SCLR: wsel.sclr = 1'b1;
        OFS_MSET: wsel.mset = 1'b1;
        OFS_MCLR: wsel.mclr = 1'b1;
        default:  wsel = '0;
      endcase
    end
  end

  always_comb begin
    assert_onehot_sel_R8: assert ($onehot0(wsel));
  end
endmodule

// File: rtl/regfront_shadow.sv
module regfront_shadow #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q[i] <= 1'b0;
      else if (clr_bits[i]) q[i] <= 1'b0;
      else if (set_bits[i]) q[i] <= 1'b1;
    end
  end

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(clr_bits)) == '0));

  assert_set_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ($past(set_bits) & ~$past(clr_bits)))
              == ($past(set_bits) & ~$past(clr_bits))));

  assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~($past(set_bits) | $past(clr_bits))) == '0));
endmodule

// File: rtl/regfront_cmd.sv
module regfront_cmd #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] bits,
  output logic [W-1:0] pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= wr ? bits : '0;
  end

  assert_no_stray_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (pulse == '0));
endmodule

// File: rtl/periph_regfront.sv
module periph_regfront
  import regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 12,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned MODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [STAT_W-1:0] evt_set,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic [MODE_W-1:0] mode,
  output logic              irq
);
  localparam int unsigned SPARE_S = DATA_W - STAT_W;
  localparam int unsigned SPARE_M = DATA_W - MODE_W;

  wr_sel_t           wsel;
  logic [STAT_W-1:0] stat_q, mask_q;
  logic [STAT_W-1:0] wbits;
  logic [DATA_W-1:0] rd_mux;

  assign wbits = wdata[STAT_W-1:0];

  regfront_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .wsel(wsel)
  );

  regfront_shadow #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_bits(evt_set | (wsel.sset ? wbits : '0)),
    .clr_bits(wsel.sclr ? wbits : '0),
    .q(stat_q)
  );

  regfront_shadow #(.W(STAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_bits(wsel.mset ? wbits : '0),
    .clr_bits(wsel.mclr ? wbits : '0),
    .q(mask_q)
  );

  regfront_cmd #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wsel.cmd),
    .bits(wdata[CMD_W-1:0]), .pulse(cmd_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode <= '0;
    else if (wsel.mode) mode <= wdata[MODE_W-1:0];
  end

  always_comb begin
    case (int'(addr))
      OFS_MODE:  rd_mux = {{SPARE_M{1'b0}}, mode};
      OFS_SVIEW: rd_mux = {{SPARE_S{1'b0}}, stat_q};
      OFS_MVIEW: rd_mux = {{SPARE_S{1'b0}}, mask_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end

  assign irq = |(stat_q & mask_q);

  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == OFS_CMD) |=> (rdata == '0));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  assert_mask_gates_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_mode_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && int'(addr) == OFS_MODE) |=> $stable(mode));
endmodule

// File: tb/periph_regfront_tb_top.sv
module periph_regfront_tb_top;
  localparam int AW = 4, DW = 32, SW = 12, CW = 8, MW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [SW-1:0] evt_set = '0;
  logic [CW-1:0] cmd_pulse;
  logic [MW-1:0] mode;
  logic          irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [SW-1:0] m_stat = '0, m_mask = '0;
  logic [MW-1:0] m_mode = '0;
  logic [CW-1:0] seen_pulse;

  always #10 clk = ~clk;

  periph_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .cmd_pulse(cmd_pulse),
    .mode(mode), .irq(irq)
  );

  function automatic logic exp_irq(logic [SW-1:0] s, logic [SW-1:0] m);
    return |(s & m);
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d, logic [SW-1:0] ev);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1; evt_set = ev;
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0; seen_pulse = cmd_pulse;
    case (a)
      1: m_mode = d[MW-1:0];
      2: m_stat = m_stat | d[SW-1:0];
      3: m_stat = m_stat & ~d[SW-1:0];
      5: m_mask = m_mask | d[SW-1:0];
      6: m_mask = m_mask & ~d[SW-1:0];
      default: ;
    endcase
    m_stat = m_stat | (ev & ~((a == 3) ? d[SW-1:0] : '0));
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; v = rdata;
  endtask

  task automatic check_all(string req);
    logic [DW-1:0] v;
    rd(4, v); check({req, " status"}, v, DW'(m_stat));
    rd(7, v); check({req, " mask"}, v, DW'(m_mask));
    check({req, " irq"}, DW'(irq), DW'(exp_irq(m_stat, m_mask)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 irq", DW'(irq), '0);
    check("R9 cmd_pulse", DW'(cmd_pulse), '0);
    check("R9 rdata", rdata, '0);
    rst_n = 1'b1;
    rd(1, v); check("R9 R5 mode reset", v, '0);
    check_all("R9");

    // R5 mode readback, upper bits zero
    wr(1, 32'hFFFF_FFFF, '0); rd(1, v); check("R5 mode mask", v, 32'h000F_FFFF);
    check("R5 mode port", DW'(mode), 32'h000F_FFFF);
    wr(1, 32'h0001_2345, '0); rd(1, v); check("R5 mode", v, 32'h0001_2345);

    // R1 / R2 set and clear, zero bits untouched
    wr(2, 32'h0000_0A05, '0); check_all("R1 set");
    wr(2, 32'h0000_0100, '0); check_all("R1 zeros keep");
    wr(3, 32'h0000_0004, '0); check_all("R2 clear");
    wr(3, 32'h0000_0000, '0); check_all("R2 zero clear");

    // R6 mask and R7 irq
    check("R7 irq no mask", DW'(irq), '0);
    wr(5, 32'hFFFF_F001, '0); check_all("R6 mask set");
    rd(7, v); check("R8 mask upper zero", v & 32'hFFFF_F000, '0);
    check("R7 irq on", DW'(irq), 32'd1);
    wr(6, 32'h0000_0001, '0); check_all("R6 mask clear");
    check("R7 irq off", DW'(irq), '0);

    // R3 event set and collision where clear wins
    wr(3, 32'h0000_0FFF, '0);
    wr(0, '0, 12'h030); check_all("R3 evt set");
    wr(3, 32'h0000_0010, 12'h090); check_all("R3 clear wins");
    rd(4, v); check("R3 bit4 cleared", v & 32'h10, '0);

    // R4 command pulses
    wr(0, 32'h0000_01A5, '0); check("R4 pulse", DW'(seen_pulse), 32'h0000_00A5);
    @(negedge clk); check("R4 single cycle", DW'(cmd_pulse), '0);
    wr(0, 32'h0, '0); check("R4 zero write", DW'(seen_pulse), '0);

    // R8 write-only and unmapped reads
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 4 || a == 7) continue;
      rd(a, v); check("R8 wo/unmapped read", v, '0);
    end
    // R10 idle cycle after read
    rd(1, v); @(negedge clk); check("R10 idle rdata", rdata, '0);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [SW-1:0] ev;
      a = int'($urandom_range(0, 7));
      ev = ($urandom_range(0, 3) == 0) ? SW'($urandom) : '0;
      wr(a, $urandom, ev);
      if (a == 0) check("R4 rand pulse", DW'(seen_pulse), DW'(wdata[CW-1:0]));
      if (n % 4 == 0) begin
        check_all("R1 R2 R3 R6 R7 rand");
        rd(1, v); check("R5 rand mode", v, DW'(m_mode));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule